// File: doc/BRIEF.md
# Semaphore-Started Descriptor Channel Sequencer

This block runs one command channel of a cipher and hash co-processor. Software writes the address of a descriptor into the channel's command pointer and then adds a count to the channel's semaphore. The sequencer is not busy and has a nonzero semaphore, so it reads an eight-word descriptor through a 32-bit read port. The descriptor holds a link, two control words, source and destination addresses, a byte count, a payload address and a status slot. The sequencer decodes the control words and starts a processing engine with a one-cycle start pulse. It then waits for the engine's done pulse and writes the result code back into the descriptor's status slot. After that it can decrement the semaphore and pulse the channel interrupt.

When one descriptor finishes, the sequencer follows the link to the next one. It fetches the next descriptor straight away while the semaphore is still nonzero. If the semaphore has dropped to zero, it waits at the new address. A zero link parks the channel. A parked channel stays idle, whatever the semaphore holds, until software adds to the semaphore again. The sequencer checks a cipher request whose byte count is not a whole number of 16-byte blocks before any engine work starts. Such a request never reaches the engine.

Top module: `desc_dma_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `irq`, `rd_req`, `wr_req` and `eng_start` are low and `sema_count` is 0.
- R2: A semaphore write adds `sema_wdata` to the 8-bit count and saturates at 255. A finished descriptor with control0 bit 1 set lowers the count by one, never below 0. With bit 1 clear the count is left unchanged.
- R3: A fetch reads eight words at the command pointer plus 0, 4, 8 ... 28, in that order. Word 0 is the link, 1 is control0, 2 is control1, 3 is source, 4 is destination, 5 is the byte count, 6 is the payload address and 7 is status. Each address is held until `rd_valid` accepts it.
- R4: The engine receives source, destination, byte count and payload from the descriptor. It also receives these flags from control0: bit 5 cipher, bit 6 hash, bit 8 encrypt, bit 9 cipher init, bit 11 key in payload, bit 12 hash init and bit 13 hash terminate. From control1 it receives bit 4 (CBC when set, ECB when clear) and bits [19:16] as the hash algorithm (0 SHA-1, 2 SHA-256). `eng_start` is a single-cycle pulse.
- R5: A descriptor with the cipher bit set and a byte count whose low four bits are not zero never starts the engine. It completes with status 0x01.
- R6: On completion, the 8-bit result, zero-extended, is written to the descriptor address plus 28. The result is `eng_status` from the engine, or the sequencer's own code. Reads and writes never overlap.
- R7: `irq` pulses high for exactly one cycle after each descriptor whose control0 bit 0 is set, and stays low otherwise.
- R8: After a descriptor with a nonzero link, the command pointer takes the link value. The next descriptor is fetched without software action if the semaphore is nonzero. Otherwise the channel idles until the next semaphore write and then fetches at the link address.
- R9: A zero link parks the channel at its current pointer, even when the semaphore is nonzero. The next semaphore write releases it, and it re-fetches at the same address.
- R10: A descriptor with neither the cipher nor the hash bit set never starts the engine and completes with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdptr_wr | input | 1 | Load the command pointer |
| cmdptr_wdata | input | 32 | Descriptor address to load |
| sema_wr | input | 1 | Add to the semaphore |
| sema_wdata | input | 8 | Amount to add |
| sema_count | output | 8 | Current semaphore count |
| busy | output | 1 | Channel is working on a descriptor |
| irq | output | 1 | One-cycle completion interrupt |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | 32 | Read byte address |
| rd_valid | input | 1 | Read data valid, accepts the request |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Status write request, held until acknowledged |
| wr_addr | output | 32 | Status write byte address |
| wr_data | output | 32 | Status write data |
| wr_ack | input | 1 | Status write acknowledge |
| eng_start | output | 1 | Engine start pulse |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_size | output | 32 | Byte count |
| eng_payload | output | 32 | Payload address (key and IV, or digest) |
| eng_cipher | output | 1 | Cipher path enabled |
| eng_hash | output | 1 | Hash path enabled |
| eng_encrypt | output | 1 | Encrypt (decrypt when low) |
| eng_cbc | output | 1 | CBC chaining (ECB when low) |
| eng_cipher_init | output | 1 | Start of a cipher stream |
| eng_key_payload | output | 1 | Payload holds the key followed by the IV |
| eng_hash_init | output | 1 | Start of a hash stream |
| eng_hash_term | output | 1 | End of a hash stream, digest goes to payload |
| eng_hash_alg | output | 4 | Hash algorithm select |
| eng_done | input | 1 | Engine finished pulse |
| eng_status | input | 8 | Engine result code |

## Verification
The bench walks a table of descriptors that covers several cases:
- cipher in ECB and CBC,
- hash with both algorithms,
- both paths together,
- neither path,
- a misaligned cipher count.

A wrong design could start the engine on the bad count or let the engine's code overwrite the sequencer's own code. It could also mis-route a flag bit. Directed tests then target the chaining rules:
- a two-descriptor chain with the semaphore at 2, which a design that stops after one would leave half done;
- a chain cut short by the semaphore reaching zero, which must resume at the link address and not at the old pointer;
- a zero link with the semaphore still nonzero, which a design that ignores parking would spin on forever.

Saturation is exercised by pushing the count past 255, which a design that wraps would leave near zero.

// File: rtl/dseq_pkg.sv
`timescale 1ns/1ps
package dseq_pkg;
  // control word 0 bit positions
  localparam int C0_IRQ         = 0;
  localparam int C0_DEC         = 1;
  localparam int C0_CIPHER      = 5;
  localparam int C0_HASH        = 6;
  localparam int C0_ENCRYPT     = 8;
  localparam int C0_CIPHER_INIT = 9;
  localparam int C0_KEY_PAYLOAD = 11;
  localparam int C0_HASH_INIT   = 12;
  localparam int C0_HASH_TERM   = 13;
  // control word 1 fields
  localparam int C1_CBC     = 4;
  localparam int C1_ALG_LSB = 16;
  localparam int C1_ALG_W   = 4;
  // descriptor word order
  localparam int DESC_WORDS = 8;
  localparam int W_NEXT     = 0;
  localparam int W_CTRL0    = 1;
  localparam int W_CTRL1    = 2;
  localparam int W_SRC      = 3;
  localparam int W_DST      = 4;
  localparam int W_SIZE     = 5;
  localparam int W_PAYLOAD  = 6;
  localparam int W_STATUS   = 7;
  localparam logic [7:0] ERR_BAD_SIZE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DISPATCH, ST_RUN, ST_WRITE, ST_FINISH
  } seq_state_t;

  typedef struct packed {
    logic                cipher_en;
    logic                hash_en;
    logic                encrypt;
    logic                cbc;
    logic                cipher_init;
    logic                key_payload;
    logic                hash_init;
    logic                hash_term;
    logic [C1_ALG_W-1:0] hash_alg;
    logic                want_dec;
    logic                want_irq;
  } op_flags_t;
endpackage

// File: rtl/dseq_sema.sv
`timescale 1ns/1ps
module dseq_sema #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] after_add;
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    sum       = {1'b0, count} + (add_en ? {1'b0, add_val} : '0);
    after_add = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    count_nxt = (dec_en && after_add != '0) ? after_add - 1'b1 : after_add;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  AST_SEMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !dec_en) |=> $stable(count)); // R2
  AST_SEMA_SAT: assert property (@(posedge clk) disable iff (rst)
    (add_en && !dec_en && (({1'b0, count} + {1'b0, add_val}) > {1'b0, CNT_MAX}))
      |=> count == CNT_MAX); // R2
  AST_SEMA_DEC: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !add_en && count != '0) |=> count == $past(count) - 1'b1); // R2
  AST_SEMA_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !add_en && count == '0) |=> count == '0); // R2
endmodule

// File: rtl/dseq_fetch.sv
`timescale 1ns/1ps
module dseq_fetch #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [WORD_W-1:0]            base_addr,
  output logic                         rd_req,
  output logic [WORD_W-1:0]            rd_addr,
  input  logic                         rd_valid,
  input  logic [WORD_W-1:0]            rd_data,
  output logic [WORDS-1:0][WORD_W-1:0] words,
  output logic                         done
);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(WORDS - 1);
  localparam logic [WORD_W-1:0] BYTES = WORD_W'(WORD_W / 8);

  logic             active;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      rd_addr <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        idx     <= '0;
        rd_addr <= base_addr;
      end else if (active && rd_valid) begin
        rd_addr <= rd_addr + BYTES;
        if (idx == LAST) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // descriptor word store, no reset so it maps to plain registers or RAM
  always_ff @(posedge clk) begin
    if (active && rd_valid) words[idx] <= rd_data;
  end

  assign rd_req = active;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> $stable(rd_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
endmodule

// File: rtl/dseq_decode.sv
`timescale 1ns/1ps
module dseq_decode
  import dseq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic [WORD_W-1:0] ctrl0,
  input  logic [WORD_W-1:0] ctrl1,
  input  logic [WORD_W-1:0] size_bytes,
  output op_flags_t         flags,
  output logic              size_bad
);
  localparam int BLK_LSB = $clog2(BLK_BYTES);

  always_comb begin
    flags.cipher_en   = ctrl0[C0_CIPHER];
    flags.hash_en     = ctrl0[C0_HASH];
    flags.encrypt     = ctrl0[C0_ENCRYPT];
    flags.cipher_init = ctrl0[C0_CIPHER_INIT];
    flags.key_payload = ctrl0[C0_KEY_PAYLOAD];
    flags.hash_init   = ctrl0[C0_HASH_INIT];
    flags.hash_term   = ctrl0[C0_HASH_TERM];
    flags.want_dec    = ctrl0[C0_DEC];
    flags.want_irq    = ctrl0[C0_IRQ];
    flags.cbc         = ctrl1[C1_CBC];
    flags.hash_alg    = ctrl1[C1_ALG_LSB +: C1_ALG_W];
  end

  assign size_bad = ctrl0[C0_CIPHER] && (size_bytes[BLK_LSB-1:0] != '0);

  logic unused_bits;
  assign unused_bits = ^{ctrl0[WORD_W-1:C0_HASH_TERM+1], ctrl0[10], ctrl0[7],
                         ctrl0[4:2], ctrl1[WORD_W-1:C1_ALG_LSB+C1_ALG_W],
                         ctrl1[C1_ALG_LSB-1:C1_CBC+1], ctrl1[C1_CBC-1:0],
                         size_bytes[WORD_W-1:BLK_LSB]};
endmodule

// File: rtl/desc_dma_seq.sv
`timescale 1ns/1ps
module desc_dma_seq
  import dseq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SEMA_W    = 8,
  parameter int STAT_W    = 8,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdptr_wr,
  input  logic [WORD_W-1:0] cmdptr_wdata,
  input  logic              sema_wr,
  input  logic [SEMA_W-1:0] sema_wdata,
  output logic [SEMA_W-1:0] sema_count,
  output logic              busy,
  output logic              irq,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              eng_start,
  output logic [WORD_W-1:0] eng_src,
  output logic [WORD_W-1:0] eng_dst,
  output logic [WORD_W-1:0] eng_size,
  output logic [WORD_W-1:0] eng_payload,
  output logic              eng_cipher,
  output logic              eng_hash,
  output logic              eng_encrypt,
  output logic              eng_cbc,
  output logic              eng_cipher_init,
  output logic              eng_key_payload,
  output logic              eng_hash_init,
  output logic              eng_hash_term,
  output logic [3:0]        eng_hash_alg,
  input  logic              eng_done,
  input  logic [STAT_W-1:0] eng_status
);
  localparam logic [WORD_W-1:0] STATUS_OFS = WORD_W'(W_STATUS * (WORD_W / 8));

  seq_state_t                       state;
  logic [WORD_W-1:0]                cmd_ptr;
  logic                             parked;
  logic                             go;
  logic                             fetch_done;
  logic                             sema_dec;
  logic [DESC_WORDS-1:0][WORD_W-1:0] words;
  op_flags_t                        flags;
  logic                             size_bad;
  logic [WORD_W-1:0]                next_ptr;

  assign go       = (state == ST_IDLE) && (sema_count != '0) && !parked;
  assign sema_dec = (state == ST_FINISH) && flags.want_dec;
  assign next_ptr = words[W_NEXT];
  assign busy     = (state != ST_IDLE);

  dseq_sema #(.CNT_W(SEMA_W)) i_sema (
    .clk(clk), .rst(rst), .add_en(sema_wr), .add_val(sema_wdata),
    .dec_en(sema_dec), .count(sema_count)
  );

  dseq_fetch #(.WORD_W(WORD_W), .WORDS(DESC_WORDS)) i_fetch (
    .clk(clk), .rst(rst), .start(go), .base_addr(cmd_ptr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .words(words), .done(fetch_done)
  );

  dseq_decode #(.WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES)) i_decode (
    .ctrl0(words[W_CTRL0]), .ctrl1(words[W_CTRL1]), .size_bytes(words[W_SIZE]),
    .flags(flags), .size_bad(size_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_ptr   <= '0;
      parked    <= 1'b0;
      irq       <= 1'b0;
      eng_start <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      irq       <= 1'b0;
      eng_start <= 1'b0;
      if (cmdptr_wr) cmd_ptr <= cmdptr_wdata;
      if (sema_wr)   parked  <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) state <= ST_FETCH;
        ST_FETCH: if (fetch_done) state <= ST_DISPATCH;
        ST_DISPATCH: begin
          if (size_bad) begin
            wr_req  <= 1'b1;
            wr_addr <= cmd_ptr + STATUS_OFS;
            wr_data <= WORD_W'(ERR_BAD_SIZE);
            state   <= ST_WRITE;
          end else if (flags.cipher_en || flags.hash_en) begin
            eng_start <= 1'b1;
            state     <= ST_RUN;
          end else begin
            wr_req  <= 1'b1;
            wr_addr <= cmd_ptr + STATUS_OFS;
            wr_data <= '0;
            state   <= ST_WRITE;
          end
        end
        ST_RUN: if (eng_done) begin
          wr_req  <= 1'b1;
          wr_addr <= cmd_ptr + STATUS_OFS;
          wr_data <= WORD_W'(eng_status);
          state   <= ST_WRITE;
        end
        ST_WRITE: if (wr_ack) begin
          wr_req <= 1'b0;
          state  <= ST_FINISH;
        end
        ST_FINISH: begin
          irq <= flags.want_irq;
          if (next_ptr != '0) cmd_ptr <= next_ptr;
          else if (!sema_wr)  parked  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eng_src         = words[W_SRC];
  assign eng_dst         = words[W_DST];
  assign eng_size        = words[W_SIZE];
  assign eng_payload     = words[W_PAYLOAD];
  assign eng_cipher      = flags.cipher_en;
  assign eng_hash        = flags.hash_en;
  assign eng_encrypt     = flags.encrypt;
  assign eng_cbc         = flags.cbc;
  assign eng_cipher_init = flags.cipher_init;
  assign eng_key_payload = flags.key_payload;
  assign eng_hash_init   = flags.hash_init;
  assign eng_hash_term   = flags.hash_term;
  assign eng_hash_alg    = flags.hash_alg;

  logic unused_bits;
  assign unused_bits = ^words[W_STATUS];

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R4
  AST_NO_START_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !size_bad); // R5
  AST_NO_START_NO_PATH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DISPATCH && !flags.cipher_en && !flags.hash_en) |=> !eng_start); // R10
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req)); // R6
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (parked && state == ST_IDLE && !sema_wr) |=> state == ST_IDLE); // R9
endmodule

// File: tb/test_desc_dma_seq.sv
`timescale 1ns/1ps
module test_desc_dma_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdptr_wr = 1'b0;
  logic [31:0] cmdptr_wdata = '0;
  logic        sema_wr = 1'b0;
  logic [7:0]  sema_wdata = '0;
  logic [7:0]  sema_count;
  logic        busy, irq, rd_req, rd_valid, wr_req, wr_ack, eng_start, eng_done;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [31:0] eng_src, eng_dst, eng_size, eng_payload;
  logic        eng_cipher, eng_hash, eng_encrypt, eng_cbc, eng_cipher_init;
  logic        eng_key_payload, eng_hash_init, eng_hash_term;
  logic [3:0]  eng_hash_alg;
  logic [7:0]  eng_ret = '0;

  always #10 clk = ~clk;

  desc_dma_seq i_desc_dma_seq (
    .clk(clk), .rst(rst), .cmdptr_wr(cmdptr_wr), .cmdptr_wdata(cmdptr_wdata),
    .sema_wr(sema_wr), .sema_wdata(sema_wdata), .sema_count(sema_count),
    .busy(busy), .irq(irq), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .eng_start(eng_start), .eng_src(eng_src),
    .eng_dst(eng_dst), .eng_size(eng_size), .eng_payload(eng_payload),
    .eng_cipher(eng_cipher), .eng_hash(eng_hash), .eng_encrypt(eng_encrypt),
    .eng_cbc(eng_cbc), .eng_cipher_init(eng_cipher_init),
    .eng_key_payload(eng_key_payload), .eng_hash_init(eng_hash_init),
    .eng_hash_term(eng_hash_term), .eng_hash_alg(eng_hash_alg),
    .eng_done(eng_done), .eng_status(eng_ret)
  );

  // memory model and engine stub
  logic [31:0] mem [0:63];
  int          eng_cnt;
  int          start_count, irq_count, acc_n;
  logic        prev_rd_req;
  logic [31:0] fetch_base, cap_src, cap_size;
  logic [11:0] cap_flags;
  logic [31:0] acc [0:7];

  always @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0; wr_ack <= 1'b0; eng_done <= 1'b0; eng_cnt = 0;
      prev_rd_req = 1'b0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      rd_data  <= mem[rd_addr[7:2]];
      wr_ack   <= wr_req && !wr_ack;
      if (wr_req && !wr_ack) mem[wr_addr[7:2]] <= wr_data;
      eng_done <= 1'b0;
      if (eng_start) begin
        eng_cnt = 3;
        start_count++;
        cap_src  = eng_src;
        cap_size = eng_size;
        cap_flags = {eng_cipher, eng_hash, eng_encrypt, eng_cbc, eng_cipher_init,
                     eng_key_payload, eng_hash_init, eng_hash_term, eng_hash_alg};
      end else if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) eng_done <= 1'b1;
      end
      if (irq) irq_count++;
      if (rd_req && !prev_rd_req) begin fetch_base = rd_addr; acc_n = 0; end
      if (rd_req && rd_valid && acc_n < 8) begin acc[acc_n] = rd_addr; acc_n++; end
      prev_rd_req = rd_req;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    start_count = 0; irq_count = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] nxt, input logic [31:0] c0,
                          input logic [31:0] c1, input logic [31:0] sz);
    mem[slot*8+0] = nxt;
    mem[slot*8+1] = c0;
    mem[slot*8+2] = c1;
    mem[slot*8+3] = 32'h1000_0000 + slot;
    mem[slot*8+4] = 32'h2000_0000 + slot;
    mem[slot*8+5] = sz;
    mem[slot*8+6] = 32'h3000_0000 + slot;
    mem[slot*8+7] = 32'hDEAD_BEEF;
  endtask

  task automatic load_ptr(input logic [31:0] a);
    @(negedge clk); cmdptr_wr = 1'b1; cmdptr_wdata = a;
    @(negedge clk); cmdptr_wr = 1'b0;
  endtask

  task automatic add_sema(input logic [7:0] v);
    @(negedge clk); sema_wr = 1'b1; sema_wdata = v;
    @(negedge clk); sema_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    int guard = 0;
    while (quiet < 6 && guard < 3000) begin
      @(negedge clk);
      if (!busy) quiet++; else quiet = 0;
      guard++;
    end
  endtask

  typedef struct packed {
    logic [31:0] c0;
    logic [31:0] c1;
    logic [31:0] size;
    logic [7:0]  ret;
    logic        xstart;
    logic [7:0]  xstat;
    logic        xirq;
    logic [7:0]  xsema;
    logic [11:0] xflags;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0000_0B23, 32'h0000_0000, 32'd32,  8'h00, 1'b1, 8'h00, 1'b1, 8'd0, 12'hAC0},
    '{32'h0000_0822, 32'h0000_0010, 32'd16,  8'h00, 1'b1, 8'h00, 1'b0, 8'd0, 12'h940},
    '{32'h0000_0023, 32'h0000_0000, 32'd20,  8'h07, 1'b0, 8'h01, 1'b1, 8'd0, 12'h000},
    '{32'h0000_3043, 32'h0002_0000, 32'd0,   8'h00, 1'b1, 8'h00, 1'b1, 8'd0, 12'h432},
    '{32'h0000_1042, 32'h0000_0000, 32'd100, 8'h05, 1'b1, 8'h05, 1'b0, 8'd0, 12'h420},
    '{32'h0000_0001, 32'h0000_0000, 32'd7,   8'h00, 1'b0, 8'h00, 1'b1, 8'd1, 12'h000},
    '{32'h0000_0162, 32'h0002_0010, 32'd48,  8'h02, 1'b1, 8'h02, 1'b0, 8'd0, 12'hF02}
  };

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check(!busy, "R1 busy", {31'b0, busy}, 0);
    check(!irq && !eng_start, "R1 irq/start", {30'b0, irq, eng_start}, 0);
    check(!rd_req && !wr_req, "R1 bus", {30'b0, rd_req, wr_req}, 0);
    check(sema_count == 0, "R1 sema", {24'b0, sema_count}, 0);

    // table walk: one descriptor per vector
    for (int v = 0; v < 7; v++) begin
      do_reset();
      eng_ret = VECS[v].ret;
      put_desc(1, 32'h0, VECS[v].c0, VECS[v].c1, VECS[v].size);
      load_ptr(32'd32);
      add_sema(8'd1);
      wait_quiet();
      check(start_count == int'(VECS[v].xstart), "R4 R5 R10 engine start count",
            start_count, {31'b0, VECS[v].xstart});
      check(mem[15] == {24'b0, VECS[v].xstat}, "R6 R5 status writeback",
            mem[15], {24'b0, VECS[v].xstat});
      check(irq_count == int'(VECS[v].xirq), "R7 interrupt count",
            irq_count, {31'b0, VECS[v].xirq});
      check(sema_count == VECS[v].xsema, "R2 semaphore after completion",
            {24'b0, sema_count}, {24'b0, VECS[v].xsema});
      if (VECS[v].xstart) begin
        check(cap_flags == VECS[v].xflags, "R4 engine flags",
              {20'b0, cap_flags}, {20'b0, VECS[v].xflags});
        check(cap_src == 32'h1000_0001 && cap_size == VECS[v].size, "R4 src/size",
              cap_src, 32'h1000_0001);
      end
      if (v == 0) begin
        for (int i = 0; i < 8; i++)
          check(acc[i] == 32'd32 + 32'(4*i), "R3 fetch order", acc[i], 32'd32 + 32'(4*i));
      end
    end

    // R8: two-descriptor chain with semaphore 2
    do_reset(); eng_ret = 8'h00;
    put_desc(1, 32'd64, 32'h0000_0823, 32'h0, 32'd16);
    put_desc(2, 32'h0,  32'h0000_0043, 32'h0, 32'd5);
    load_ptr(32'd32);
    add_sema(8'd2);
    wait_quiet();
    check(start_count == 2, "R8 chain both run", start_count, 2);
    check(irq_count == 2, "R7 R8 chain irqs", irq_count, 2);
    check(sema_count == 0, "R2 R8 chain sema", {24'b0, sema_count}, 0);
    check(mem[15] == 0 && mem[23] == 0, "R6 R8 chain status", mem[23], 0);
    check(acc[7] == 32'd92, "R3 second fetch last word", acc[7], 32'd92);

    // R8: chain stops with semaphore at zero, resumes at link
    do_reset();
    put_desc(1, 32'd64, 32'h0000_0822, 32'h0, 32'd16);
    put_desc(2, 32'h0,  32'h0000_0042, 32'h0, 32'd5);
    load_ptr(32'd32);
    add_sema(8'd1);
    wait_quiet();
    check(start_count == 1, "R8 stop at zero semaphore", start_count, 1);
    check(mem[23] == 32'hDEAD_BEEF, "R8 second untouched", mem[23], 32'hDEAD_BEEF);
    add_sema(8'd1);
    wait_quiet();
    check(start_count == 2, "R8 resume run", start_count, 2);
    check(fetch_base == 32'd64, "R8 resume at link", fetch_base, 32'd64);

    // R9: zero link parks with semaphore nonzero
    do_reset();
    put_desc(1, 32'h0, 32'h0000_0040, 32'h0, 32'd8);
    load_ptr(32'd32);
    add_sema(8'd1);
    wait_quiet();
    repeat (20) @(negedge clk);
    check(start_count == 1 && !busy, "R9 parked", start_count, 1);
    check(sema_count == 1, "R2 R9 no decrement", {24'b0, sema_count}, 1);
    add_sema(8'd1);
    wait_quiet();
    check(start_count == 2, "R9 released", start_count, 2);
    check(fetch_base == 32'd32, "R9 same address", fetch_base, 32'd32);

    // R2: saturation
    add_sema(8'd250);
    wait_quiet();
    check(sema_count == 8'd252, "R2 add", {24'b0, sema_count}, 32'd252);
    add_sema(8'd10);
    wait_quiet();
    check(sema_count == 8'd255, "R2 saturate", {24'b0, sema_count}, 32'd255);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule